// File: doc/BRIEF.md
# Ripple-Carry Integer ALU

This block is a purely combinational 32-bit arithmetic logic unit for a simple integer datapath. It takes two two's-complement operands and a three-bit control word, and in the same cycle returns a result word, a flag that is set when the result is all zeros, and a signed-overflow flag. It supports five functions: bitwise AND, bitwise OR, add, subtract, and a signed set-if-less comparison.

The datapath is a chain of identical one-bit slices. Each slice holds a full adder and a small result multiplexer. Carries ripple from bit 0 upward, with no lookahead. One control bit inverts every B input and also supplies the carry into bit 0, so a single adder serves add, subtract and compare. The compare outcome is formed at the top slice. It is the sign of A minus B corrected by the overflow condition, and it is routed back into bit 0 of the result. Sign or zero extension of immediates is done before the operands reach the block.

Top module: `ralu_top`

## Requirements
- R1: Control 3'b000 returns A AND B bit by bit, and control 3'b001 returns A OR B bit by bit.
- R2: Control 3'b010 returns A plus B modulo 2^32.
- R3: Control 3'b110 returns A minus B modulo 2^32. B is inverted and the carry into bit 0 is 1, so the carry out of the top bit is 1 exactly when A is at least B as unsigned numbers.
- R4: For controls 3'b010 and 3'b110, the overflow output is 1 exactly when the signed result does not fit in 32 bits. That is the carry into the top bit XOR the carry out of it.
- R5: Control 3'b111 returns 1 in bit 0 when A is less than B as signed numbers, and 0 in bit 0 otherwise. This holds even when A minus B overflows. Bits 31 to 1 are 0.
- R6: The zero output is 1 exactly when all 32 result bits are 0, for every control value.
- R7: The overflow output is 0 for controls 3'b000, 3'b001 and 3'b111.
- R8: The unused controls 3'b011, 3'b100 and 3'b101 give a result of 0, a zero output of 1 and an overflow output of 0.
- R9: A carry propagates through all 32 slices. For example, 0xFFFFFFFF plus 1 gives 0, with zero set and overflow clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A, two's complement |
| b_i | input | 32 | Operand B, two's complement |
| ctl_i | input | 3 | {invert-B bit, operation select[1:0]} |
| res_o | output | 32 | Result word |
| zero_o | output | 1 | 1 when the result is all zeros |
| ovf_o | output | 1 | Signed overflow for add and subtract |

## Verification
The block has no state, so any fault in the inversion path, a broken carry link or a wrong compare correction shows up at the ports within the cycle the operands are applied. A dropped carry link appears only for operands whose carry chain reaches that slice. For this reason, the stimulus includes long-propagate values such as all-ones plus one, alongside random operands. A compare that uses the raw sign instead of the corrected one differs from the reference only when the subtraction overflows. Operand pairs built from 0x7FFFFFFF and 0x80000000 are therefore driven deliberately.

// File: rtl/ralu_pkg.sv
package ralu_pkg;
  localparam int CTL_W = 3;

  typedef enum logic [CTL_W-1:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_ctl_e;

  function automatic logic ctl_is_valid(input logic [CTL_W-1:0] c);
    return (c == ALU_AND) || (c == ALU_OR) || (c == ALU_ADD) ||
           (c == ALU_SUB) || (c == ALU_SLT);
  endfunction

  function automatic logic parity3(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic majority3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/ralu_slice.sv
module ralu_slice
  import ralu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       carry_i,
  input  logic       bneg_i,
  input  logic [1:0] op_i,
  input  logic       less_i,
  output logic       res_o,
  output logic       sum_o,
  output logic       carry_o
);
  logic b_eff;

  assign b_eff   = b_i ^ bneg_i;
  assign sum_o   = parity3(a_i, b_eff, carry_i);
  assign carry_o = majority3(a_i, b_eff, carry_i);

  always_comb begin
    unique case (op_i)
      2'b00:   res_o = a_i & b_eff;
      2'b01:   res_o = a_i | b_eff;
      2'b10:   res_o = sum_o;
      default: res_o = less_i;
    endcase
  end
endmodule

// File: rtl/ralu_zero.sv
module ralu_zero #(
  parameter int W = 32
) (
  input  logic [W-1:0] vec_i,
  output logic         zero_o
);
  assign zero_o = ~(|vec_i);
endmodule

// File: rtl/ralu_top.sv
module ralu_top
  import ralu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       ctl_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic             bneg;
  logic [1:0]       op_sel;
  logic             ctl_valid;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] less_vec;
  logic [WIDTH-1:0] slice_res;
  logic [WIDTH-1:0] sum_vec;
  logic             carry_into_msb;
  logic             carry_out_msb;
  logic             ovf_raw;
  logic             less_flag;

  assign bneg      = ctl_i[2];
  assign op_sel    = ctl_i[1:0];
  assign ctl_valid = ctl_is_valid(ctl_i);
  assign carry[0]  = bneg;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == 0) begin : g_lsb
      assign less_vec[i] = less_flag;
    end else begin : g_rest
      assign less_vec[i] = 1'b0;
    end
    ralu_slice u_slice (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .carry_i (carry[i]),
      .bneg_i  (bneg),
      .op_i    (op_sel),
      .less_i  (less_vec[i]),
      .res_o   (slice_res[i]),
      .sum_o   (sum_vec[i]),
      .carry_o (carry[i+1])
    );
  end

  assign carry_into_msb = carry[MSB];
  assign carry_out_msb  = carry[WIDTH];
  assign ovf_raw        = carry_into_msb ^ carry_out_msb;
  assign less_flag      = sum_vec[MSB] ^ ovf_raw;

  assign res_o = ctl_valid ? slice_res : '0;
  assign ovf_o = ctl_valid && (op_sel == 2'b10) && ovf_raw;

  ralu_zero #(.W(WIDTH)) u_zero (
    .vec_i  (res_o),
    .zero_o (zero_o)
  );
endmodule

// File: rtl/ralu_chk.sv
module ralu_chk
  import ralu_pkg::*;
#(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   ctl_i,
  input logic [W-1:0] res_o,
  input logic         zero_o,
  input logic         ovf_o,
  input logic [W-1:0] sum_vec,
  input logic         carry_out_msb,
  input logic         less_flag
);
  always_comb begin
    // R6
    zero_flag_chk: assert (zero_o == (res_o == '0));
    if (ctl_i == ALU_AND || ctl_i == ALU_OR || ctl_i == ALU_SLT) begin
      // R7
      no_overflow_chk: assert (!ovf_o);
    end
    if (ctl_i == ALU_SLT) begin
      // R5
      slt_shape_chk: assert (res_o[W-1:1] == '0 && res_o[0] == less_flag);
    end
    if (!ctl_is_valid(ctl_i)) begin
      // R8
      unused_ctl_chk: assert (res_o == '0 && !ovf_o);
    end
    if (ctl_i == ALU_ADD) begin
      // R4
      add_overflow_chk: assert (ovf_o == ((a_i[W-1] == b_i[W-1]) && (res_o[W-1] != a_i[W-1])));
    end
    if (ctl_i == ALU_SUB) begin
      // R3
      sub_diff_chk: assert (sum_vec == W'(a_i - b_i));
      // R3
      sub_borrow_chk: assert (carry_out_msb == (a_i >= b_i));
    end
  end
endmodule

bind ralu_top ralu_chk #(.W(WIDTH)) u_chk (
  .a_i           (a_i),
  .b_i           (b_i),
  .ctl_i         (ctl_i),
  .res_o         (res_o),
  .zero_o        (zero_o),
  .ovf_o         (ovf_o),
  .sum_vec       (sum_vec),
  .carry_out_msb (carry_out_msb),
  .less_flag     (less_flag)
);

// File: tb/ralu_top_test.sv
module ralu_top_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a, b;
  logic [2:0]   ctl;
  logic [W-1:0] res;
  logic         zero, ovf;
  int           total = 0;
  int           bad = 0;
  int           cycles = 0;

  always #2 clk = ~clk;

  ralu_top #(.WIDTH(W)) uut (
    .a_i(a), .b_i(b), .ctl_i(ctl), .res_o(res), .zero_o(zero), .ovf_o(ovf)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [W-1:0] exp_res(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic [2:0] c);
    case (c)
      3'b000:  return x & y;
      3'b001:  return x | y;
      3'b010:  return x + y;
      3'b110:  return x - y;
      3'b111:  return {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [2:0] c);
    longint sx, sy, r;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    if (c == 3'b010) r = sx + sy;
    else if (c == 3'b110) r = sx - sy;
    else return 1'b0;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  function automatic string res_tag(input logic [2:0] c);
    case (c)
      3'b000, 3'b001: return "R1";
      3'b010:         return "R2";
      3'b110:         return "R3";
      3'b111:         return "R5";
      default:        return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    total = total + 1;
    if (act !== expv) begin
      bad = bad + 1;
      $display("FAIL %s: a=%h b=%h ctl=%b actual=%h expected=%h", tag, a, b, ctl, act, expv);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] c);
    logic [W-1:0] er;
    @(negedge clk);
    a = x; b = y; ctl = c;
    #1;
    er = exp_res(x, y, c);
    check(res_tag(c), res, er);
    check("R6", W'(zero), W'(er == '0));
    if (c == 3'b010 || c == 3'b110) check("R4", W'(ovf), W'(exp_ovf(x, y, c)));
    else check(c == 3'b111 || c[2:1] == 2'b00 ? "R7" : "R8", W'(ovf), '0);
  endtask

  logic [W-1:0] corners [6];
  logic [2:0]   codes [8];

  initial begin
    void'($urandom(32'd4242));
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001; corners[2] = 32'h7FFF_FFFF;
    corners[3] = 32'h8000_0000; corners[4] = 32'hFFFF_FFFF; corners[5] = 32'h8000_0001;
    codes[0] = 3'b000; codes[1] = 3'b001; codes[2] = 3'b010; codes[3] = 3'b110;
    codes[4] = 3'b111; codes[5] = 3'b011; codes[6] = 3'b100; codes[7] = 3'b101;
    a = '0; b = '0; ctl = 3'b000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // idle state with zero inputs: AND of zeros
    check("R6", W'(zero), W'(1));
    check("R1", res, '0);

    // R9: full-length carry propagation
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);
    check("R9", W'(zero), W'(1));
    apply(32'h0000_0000, 32'h0000_0001, 3'b110);
    check("R9", res, 32'hFFFF_FFFF);

    // R5: compare with overflowing subtraction
    apply(32'h8000_0000, 32'h7FFF_FFFF, 3'b111);
    check("R5", res, 32'h1);
    apply(32'h7FFF_FFFF, 32'h8000_0000, 3'b111);
    check("R5", res, 32'h0);
    // R4: positive overflow on add, negative on subtract
    apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);
    check("R4", W'(ovf), W'(1));
    apply(32'h8000_0000, 32'h0000_0001, 3'b110);
    check("R4", W'(ovf), W'(1));
    // R6: equality via subtract
    apply(32'h1234_5678, 32'h1234_5678, 3'b110);
    check("R6", W'(zero), W'(1));

    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int k = 0; k < 8; k++)
          apply(corners[i], corners[j], codes[k]);

    for (int n = 0; n < 2000; n++) begin
      logic [W-1:0] x, y;
      x = ($urandom % 4 == 0) ? corners[$urandom % 6] : $urandom;
      y = ($urandom % 4 == 0) ? corners[$urandom % 6] : $urandom;
      if (n % 7 == 0) y = x;
      apply(x, y, codes[$urandom % 8]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule